// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block decides whether one local interrupt controller is among the targets of an inter-processor interrupt. A sender presents a destination field, a physical-or-logical mode bit, a shorthand code and a flag telling whether this unit is the sender. The unit also sees its own physical ID, its logical ID and the format code of its logical addressing scheme. From these it produces one match bit, together with an error flag. The error flag marks a decision that had no valid encoding to work from.

Logical addressing comes in two forms. In flat form every logical ID bit selects a group. In cluster form the upper half of the ID names a cluster and the lower half selects members within it. Physical addressing compares the destination with the unit's ID, and the all-ones destination reaches every unit. The decision itself is combinational. By default it is captured in an output register, so the result and a valid strobe appear one clock after the request is sampled. A system instantiates one copy of this block per local unit and gathers the match bits.

Top module: `ipi_dest_match`

## Requirements
- R1: Shorthand code 1 (self) matches exactly when `src_is_self` is 1, whatever the destination, mode and format are.
- R2: Shorthand code 2 (all including self) always matches.
- R3: Shorthand code 3 (all excluding self) matches exactly when `src_is_self` is 0.
- R4: Shorthand code 0 with `dest_logical`=0 matches when `dest_id` is all ones (0xFF) or when it equals `own_id`.
- R5: Shorthand code 0 with `dest_logical`=1 and `dest_format`=4'hF (flat) matches when the bitwise AND of `log_id` and `dest_id` is nonzero.
- R6: Shorthand code 0 with `dest_logical`=1 and `dest_format`=4'h0 (cluster) matches when bits 7:4 of `log_id` and `dest_id` are equal and the AND of their bits 3:0 is nonzero.
- R7: Shorthand code 0 with `dest_logical`=1 and any `dest_format` other than 4'hF or 4'h0 gives no match and raises `cfg_err`. The format is ignored in physical mode and under shorthands 1 to 3, where `cfg_err` stays 0.
- R8: Shorthand codes 4 to 7 are undefined: they give no match and raise `cfg_err`.
- R9: `out_valid` equals the value `in_valid` had one clock earlier. `match` and `cfg_err` belong to the request sampled in that same cycle, and both are 0 whenever `out_valid` is 0 and during reset.
- R10: `cfg_err` and `match` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| dest_id | input | 8 | Destination field of the request |
| dest_logical | input | 1 | 0 physical, 1 logical addressing |
| shorthand | input | 3 | 0 none, 1 self, 2 all incl. self, 3 all excl. self, 4-7 undefined |
| src_is_self | input | 1 | This unit is the sender |
| own_id | input | 8 | Physical ID of this unit |
| log_id | input | 8 | Logical ID of this unit |
| dest_format | input | 4 | Logical format: 4'hF flat, 4'h0 cluster, others invalid |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| match | output | 1 | This unit is a target |
| cfg_err | output | 1 | Invalid shorthand or format forced no match |

## Verification
The assertions assume that the inputs are stable across the sampling edge. They also assume that the result register is present, which is the default. The stimulus respects this by changing every input on the falling clock edge only. The properties relate one cycle's request fields to the next cycle's outputs, so they need nothing beyond that timing. The stimulus is biased so that the destination often equals the unit's ID, the broadcast value or a cluster-matching pattern. It covers every shorthand code, including the undefined ones, and both valid and invalid format nibbles. Cycles with `in_valid` low are mixed in as well.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

    localparam int SH_W  = 3;
    localparam int FMT_W = 4;

    typedef enum logic [SH_W-1:0] {
        SH_NONE    = 3'd0,
        SH_SELF    = 3'd1,
        SH_ALL_INC = 3'd2,
        SH_ALL_EXC = 3'd3
    } shorthand_e;

    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        LF_FLAT,
        LF_CLUSTER,
        LF_BAD
    } log_fmt_e;

    typedef struct packed {
        logic hit;
        logic err;
    } decision_t;

endpackage

// File: rtl/ipi_phys_match.sv
module ipi_phys_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] own_id,
    input  logic [ID_W-1:0] dest_id,
    output logic            hit
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic is_bcast;
    logic is_mine;

    always_comb begin
        is_bcast = (dest_id == BCAST);
        is_mine  = (dest_id == own_id);
        hit      = is_bcast | is_mine;
    end
endmodule

// File: rtl/ipi_logical_match.sv
module ipi_logical_match
    import ipi_dest_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0]  log_id,
    input  logic [ID_W-1:0]  dest_id,
    input  logic [FMT_W-1:0] dest_format,
    output logic             hit,
    output logic             fmt_bad
);
    localparam int HALF_W = ID_W / 2;

    log_fmt_e        fmt_kind;
    logic            flat_hit;
    logic            clus_same;
    logic            clus_member;
    logic [ID_W-1:0] overlap;

    always_comb begin
        if (dest_format == FMT_FLAT)
            fmt_kind = LF_FLAT;
        else if (dest_format == FMT_CLUSTER)
            fmt_kind = LF_CLUSTER;
        else
            fmt_kind = LF_BAD;
    end

    always_comb begin
        overlap     = log_id & dest_id;
        flat_hit    = |overlap;
        clus_same   = (log_id[ID_W-1:HALF_W] == dest_id[ID_W-1:HALF_W]);
        clus_member = |overlap[HALF_W-1:0];
    end

    always_comb begin
        hit     = 1'b0;
        fmt_bad = 1'b0;
        unique case (fmt_kind)
            LF_FLAT:    hit = flat_hit;
            LF_CLUSTER: hit = clus_same & clus_member;
            default:    fmt_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_dest_pkg::*;
#(
    parameter int ID_W         = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ID_W-1:0]  dest_id,
    input  logic             dest_logical,
    input  logic [SH_W-1:0]  shorthand,
    input  logic             src_is_self,
    input  logic [ID_W-1:0]  own_id,
    input  logic [ID_W-1:0]  log_id,
    input  logic [FMT_W-1:0] dest_format,
    output logic             out_valid,
    output logic             match,
    output logic             cfg_err
);
    localparam logic [ID_W-1:0] BCAST  = {ID_W{1'b1}};
    localparam int              HALF_W = ID_W / 2;

    logic      phys_hit;
    logic      log_hit;
    logic      log_bad;
    decision_t dec;

    ipi_phys_match #(.ID_W(ID_W)) phys_i (
        .own_id  (own_id),
        .dest_id (dest_id),
        .hit     (phys_hit)
    );

    ipi_logical_match #(.ID_W(ID_W)) logic_i (
        .log_id      (log_id),
        .dest_id     (dest_id),
        .dest_format (dest_format),
        .hit         (log_hit),
        .fmt_bad     (log_bad)
    );

    // Shorthand selects which address path decides the result.
    always_comb begin
        dec = '0;
        unique case (shorthand)
            SH_NONE: begin
                if (dest_logical) begin
                    dec.hit = log_hit;
                    dec.err = log_bad;
                end else begin
                    dec.hit = phys_hit;
                end
            end
            SH_SELF:    dec.hit = src_is_self;
            SH_ALL_INC: dec.hit = 1'b1;
            SH_ALL_EXC: dec.hit = ~src_is_self;
            default:    dec.err = 1'b1;
        endcase
    end

    generate
        if (REGISTER_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    match     <= 1'b0;
                    cfg_err   <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    match     <= in_valid & dec.hit;
                    cfg_err   <= in_valid & dec.err;
                end
            end

            p_self_r1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_SELF |=> match == $past(src_is_self));

            p_all_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_ALL_INC |=> match);

            p_all_exc_r3: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_ALL_EXC |=> match != $past(src_is_self));

            p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_NONE && !dest_logical && dest_id == BCAST
                |=> match);

            p_flat_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_NONE && dest_logical &&
                dest_format == FMT_FLAT && (log_id & dest_id) == '0 |=> !match);

            p_cluster_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_NONE && dest_logical &&
                dest_format == FMT_CLUSTER &&
                log_id[ID_W-1:HALF_W] != dest_id[ID_W-1:HALF_W] |=> !match);

            p_bad_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand == SH_NONE && dest_logical &&
                dest_format != FMT_FLAT && dest_format != FMT_CLUSTER
                |=> cfg_err && !match);

            p_bad_sh_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && shorthand > SH_ALL_EXC |=> cfg_err && !match);

            p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> out_valid == $past(in_valid));

            p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !out_valid |-> !match && !cfg_err);

            p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_err && match));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign match     = in_valid & dec.hit;
            assign cfg_err   = in_valid & dec.err;
        end
    endgenerate
endmodule

// File: tb/ipi_dest_match_tb.sv
`timescale 1ns/1ps
module ipi_dest_match_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] dest_id = '0;
    logic       dest_logical = 1'b0;
    logic [2:0] shorthand = '0;
    logic       src_is_self = 1'b0;
    logic [7:0] own_id = '0;
    logic [7:0] log_id = '0;
    logic [3:0] dest_format = '0;
    logic       out_valid, match, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Expectation for the request sampled at the coming edge.
    bit    exp_v = 0, exp_m = 0, exp_e = 0;
    string exp_tag = "R9";

    always #2 clk = ~clk;

    ipi_dest_match dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest_id(dest_id),
        .dest_logical(dest_logical), .shorthand(shorthand), .src_is_self(src_is_self),
        .own_id(own_id), .log_id(log_id), .dest_format(dest_format),
        .out_valid(out_valid), .match(match), .cfg_err(cfg_err)
    );

    function automatic void model(input bit v, input bit [7:0] d, input bit lg,
                                  input int sh, input bit slf, input bit [7:0] oid,
                                  input bit [7:0] lid, input bit [3:0] fmt,
                                  output bit m, output bit e, output string tag);
        m = 0; e = 0; tag = "R9";
        if (!v) return;
        if (sh == 1) begin m = slf; tag = "R1"; end
        else if (sh == 2) begin m = 1; tag = "R2"; end
        else if (sh == 3) begin m = !slf; tag = "R3"; end
        else if (sh >= 4) begin e = 1; tag = "R8"; end
        else if (!lg) begin m = (d == 8'hFF) || (d == oid); tag = "R4"; end
        else if (fmt == 4'hF) begin m = (lid & d) != 0; tag = "R5"; end
        else if (fmt == 4'h0) begin
            m = (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0); tag = "R6";
        end else begin e = 1; tag = "R7"; end
    endfunction

    task automatic check_outputs();
        checks++;
        if (out_valid !== exp_v || match !== exp_m || cfg_err !== exp_e) begin
            failures++;
            $display("FAIL %s/R10: got v=%0b m=%0b e=%0b expected v=%0b m=%0b e=%0b",
                     exp_tag, out_valid, match, cfg_err, exp_v, exp_m, exp_e);
        end
    endtask

    task automatic step(input bit v, input bit [7:0] d, input bit lg, input int sh,
                        input bit slf, input bit [7:0] oid, input bit [7:0] lid,
                        input bit [3:0] fmt);
        bit m, e;
        string t;
        @(negedge clk);
        check_outputs();
        in_valid = v; dest_id = d; dest_logical = lg; shorthand = sh[2:0];
        src_is_self = slf; own_id = oid; log_id = lid; dest_format = fmt;
        model(v, d, lg, sh, slf, oid, lid, fmt, m, e, t);
        exp_v = v; exp_m = m; exp_e = e; exp_tag = t;
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got running expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_outputs();
        rst_n = 1'b1;
        // R1 self, both source flags
        step(1, 8'h12, 0, 1, 1, 8'h03, 8'h00, 4'h5);
        step(1, 8'h03, 0, 1, 0, 8'h03, 8'h00, 4'hF);
        // R2 all-including
        step(1, 8'h00, 1, 2, 0, 8'h03, 8'h00, 4'h7);
        step(1, 8'h00, 0, 2, 1, 8'h03, 8'h00, 4'h0);
        // R3 all-excluding
        step(1, 8'hFF, 0, 3, 1, 8'h03, 8'h00, 4'hF);
        step(1, 8'h00, 0, 3, 0, 8'h03, 8'h00, 4'h9);
        // R4 physical: own, broadcast, miss
        step(1, 8'h03, 0, 0, 0, 8'h03, 8'h00, 4'h6);
        step(1, 8'hFF, 0, 0, 0, 8'h03, 8'h00, 4'h6);
        step(1, 8'h04, 0, 0, 1, 8'h03, 8'h04, 4'hF);
        // R5 flat: overlap and none
        step(1, 8'h81, 1, 0, 0, 8'h81, 8'h01, 4'hF);
        step(1, 8'h7E, 1, 0, 0, 8'h7E, 8'h81, 4'hF);
        // R6 cluster: hit, wrong cluster, empty member set
        step(1, 8'h35, 1, 0, 0, 8'h00, 8'h31, 4'h0);
        step(1, 8'h45, 1, 0, 0, 8'h00, 8'h31, 4'h0);
        step(1, 8'h32, 1, 0, 0, 8'h00, 8'h31, 4'h0);
        // R7 invalid format, even when the IDs would match
        step(1, 8'hFF, 1, 0, 0, 8'hFF, 8'hFF, 4'h8);
        step(1, 8'h11, 1, 0, 1, 8'h11, 8'h11, 4'h1);
        // R8 undefined shorthands
        for (int s = 4; s < 8; s++) step(1, 8'hFF, 0, s, 1, 8'hFF, 8'hFF, 4'hF);
        // R9 idle cycles with active-looking fields
        step(0, 8'hFF, 0, 2, 1, 8'hFF, 8'hFF, 4'hF);
        step(0, 8'h00, 1, 5, 0, 8'h00, 8'h00, 4'h3);
        // Mixed patterns
        for (int i = 0; i < 400; i++) begin
            bit [7:0] oid = 8'($urandom);
            bit [7:0] lid = 8'($urandom);
            bit [7:0] d;
            bit [3:0] f;
            int sel = $urandom % 4;
            d = (sel == 0) ? oid : (sel == 1) ? 8'hFF :
                (sel == 2) ? {lid[7:4], 4'($urandom)} : 8'($urandom);
            sel = $urandom % 3;
            f = (sel == 0) ? 4'hF : (sel == 1) ? 4'h0 : 4'($urandom);
            step(($urandom % 5) != 0, d, 1'($urandom), ($urandom % 3 == 0) ? int'($urandom % 8) : 0,
                 1'($urandom), oid, lid, f);
        end
        step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 4'h0);
        step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 4'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule